// File: doc/BRIEF.md
# Configurable Registered Output Cell Bank

This block is the output stage of a small sum-of-products logic fabric. Each cell takes one sum term from the array, a per-cell enable term, the pad's input value and four configuration bits. It returns a pad drive value, a pad drive enable and one feedback bit for the array. A cell holds a single storage bit. That bit loads the sum term on a rising edge of the selected clock. It is forced high on such an edge by a global preset term and is forced low at once by a global clear term. The cell output is either the stored bit or the raw sum term, with programmable inversion.

One clock selector serves all cells. It picks either a pin clock or a product-term clock and uses it in true or inverted form. The selected signal is sampled on the system clock. Each rising transition it shows produces a one-cycle load strobe, so the whole block runs on one system clock. The pad is modelled as separate out, enable and in signals, which a pad ring joins into a tri-state pin.

Top module: `mc_bank`

## Requirements
- R1: When the selected clock shows a rising transition, each cell's stored bit takes its sum term at the next system clock edge. In every other cycle the stored bit keeps its value, unless clear is asserted.
- R2: If the preset term is true on a selected-clock rising transition, the stored bit becomes 1 whatever the sum term is. If the preset term is true without such a transition, it has no effect.
- R3: While the clear term is true, the stored bit reads 0 on the outputs in the same cycle, with no clock edge needed, and the register holds 0 afterwards.
- R4: When the clear and preset terms are both true on a selected-clock transition, the stored bit becomes 0.
- R5: Configuration bit 0 sets polarity. A value of 1 drives the selected value unchanged (active-high). A value of 0 drives its inverse (active-low).
- R6: Configuration bit 1 selects the output source. A value of 1 drives the stored bit (registered). A value of 0 drives the sum term (combinational).
- R7: pad_oe for a cell equals that cell's enable term. When the enable term is false the pad is released.
- R8: Configuration bits 3:2 select the feedback source: 00 gives the pad input, 01 gives the raw sum term and 10 gives the stored bit. Sum-term feedback also works while the pad is released.
- R9: The clock source bit picks the pin clock (0) or the product-term clock (1), and the invert bit complements it. Transitions on the unselected clock have no effect.
- R10: The configuration codes with bits 3:1 equal to 110 or 111 are unused. They act as combinational, active-high, pad-input feedback, whatever the value of bit 0.
- R11: Reset clears every stored bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, clears the stored bits |
| pin_clk | input | 1 | Clock candidate from a dedicated pin |
| pt_clk | input | 1 | Clock candidate from a product term |
| clk_src_pt | input | 1 | 1 selects pt_clk, 0 selects pin_clk |
| clk_invert | input | 1 | 1 uses the complement of the selected clock |
| preset_term | input | 1 | Global synchronous preset term |
| clear_term | input | 1 | Global immediate clear term |
| cell_cfg | input | 4*N_CELLS | Four configuration bits per cell; cell i uses bits 4i+3..4i |
| sum_term | input | N_CELLS | Sum term per cell |
| oe_term | input | N_CELLS | Output enable term per cell |
| pad_i | input | N_CELLS | Value seen on each pad |
| pad_o | output | N_CELLS | Value driven to each pad |
| pad_oe | output | N_CELLS | Drive enable per pad |
| fb_o | output | N_CELLS | Feedback bit per cell returned to the array |

## Verification
The bench goes after the precedence and timing corners. It applies clear and preset in the same cycle, which a design with the priority swapped would answer with a 1. It checks clear in the middle of a cycle, where a design that only clears on an edge would still show the old 1. It raises the unselected clock, which a wrong multiplexer would turn into a load. It changes the source selection while the new source is already high, and it drives the inverted pin clock, where a design without inversion would load on the wrong transition. It also holds preset without any clock transition. The unused configuration codes and sum-term feedback with the pad released run in every step, so a design that falls back to registered output or gates feedback with the enable shows wrong values on the pad or on the feedback bit.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int CFG_W = 4;

    typedef enum logic [1:0] {
        FB_PAD  = 2'd0,
        FB_SUM  = 2'd1,
        FB_STOR = 2'd2
    } fb_src_e;

    typedef struct packed {
        logic    registered;
        logic    active_high;
        fb_src_e fb;
    } cell_mode_t;

    // bit0 polarity, bit1 output source, bits3:2 feedback source
    function automatic cell_mode_t decode_cell(input logic [CFG_W-1:0] bits);
        cell_mode_t m;
        m.registered  = 1'b0;
        m.active_high = 1'b1;
        m.fb          = FB_PAD;
        case (bits[3:1])
            3'b000, 3'b001, 3'b010, 3'b011, 3'b100, 3'b101: begin
                m.registered  = bits[1];
                m.active_high = bits[0];
                case (bits[3:2])
                    2'b01:   m.fb = FB_SUM;
                    2'b10:   m.fb = FB_STOR;
                    default: m.fb = FB_PAD;
                endcase
            end
            default: ;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mc_clock_sel.sv
module mc_clock_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_clk_i,
    input  logic pt_clk_i,
    input  logic src_pt_i,
    input  logic invert_i,
    output logic load_o
);

    typedef struct packed {
        logic prev;
    } sel_state_t;

    sel_state_t st_d, st_q;
    logic       chosen;

    always_comb begin
        chosen = (src_pt_i ? pt_clk_i : pin_clk_i) ^ invert_i;
        st_d   = st_q;
        st_d.prev = chosen;
        load_o = chosen & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R9: a single transition yields a single strobe
    p_single_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);

    // R9: strobe only while the selected clock is high
    p_strobe_needs_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> chosen);

endmodule

// File: rtl/mc_cell.sv
module mc_cell
    import mc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             preset_i,
    input  logic             clear_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             sum_i,
    input  logic             oe_i,
    input  logic             pad_i,
    output logic             pad_o,
    output logic             pad_oe,
    output logic             fb_o
);

    typedef struct packed {
        logic stored;
    } cell_state_t;

    cell_state_t st_d, st_q;
    cell_mode_t  mode;
    logic        stored_view;
    logic        out_raw;

    always_comb begin
        mode = decode_cell(cfg_i);
        st_d = st_q;
        if (clear_i) begin
            st_d.stored = 1'b0;
        end else if (load_i) begin
            st_d.stored = preset_i ? 1'b1 : sum_i;
        end

        stored_view = clear_i ? 1'b0 : st_q.stored;
        out_raw     = mode.registered ? stored_view : sum_i;
        pad_o       = mode.active_high ? out_raw : ~out_raw;
        pad_oe      = oe_i;

        case (mode.fb)
            FB_SUM:  fb_o = sum_i;
            FB_STOR: fb_o = stored_view;
            default: fb_o = pad_i;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.stored <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !preset_i && !clear_i) |=> (st_q.stored == $past(sum_i)));

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !clear_i) |=> $stable(st_q.stored));

    p_preset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && preset_i && !clear_i) |=> st_q.stored);

    p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> !st_q.stored);

endmodule

// File: rtl/mc_bank.sv
module mc_bank
    import mc_pkg::*;
#(
    parameter int N_CELLS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pin_clk,
    input  logic                     pt_clk,
    input  logic                     clk_src_pt,
    input  logic                     clk_invert,
    input  logic                     preset_term,
    input  logic                     clear_term,
    input  logic [CFG_W*N_CELLS-1:0] cell_cfg,
    input  logic [N_CELLS-1:0]       sum_term,
    input  logic [N_CELLS-1:0]       oe_term,
    input  logic [N_CELLS-1:0]       pad_i,
    output logic [N_CELLS-1:0]       pad_o,
    output logic [N_CELLS-1:0]       pad_oe,
    output logic [N_CELLS-1:0]       fb_o
);

    logic load;

    mc_clock_sel i_clk_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_clk_i (pin_clk),
        .pt_clk_i  (pt_clk),
        .src_pt_i  (clk_src_pt),
        .invert_i  (clk_invert),
        .load_o    (load)
    );

    for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
        mc_cell i_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .load_i   (load),
            .preset_i (preset_term),
            .clear_i  (clear_term),
            .cfg_i    (cell_cfg[g*CFG_W +: CFG_W]),
            .sum_i    (sum_term[g]),
            .oe_i     (oe_term[g]),
            .pad_i    (pad_i[g]),
            .pad_o    (pad_o[g]),
            .pad_oe   (pad_oe[g]),
            .fb_o     (fb_o[g])
        );
    end

    // R7: released pads follow the enable term at the block edge
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_term[0]) |-> !pad_oe[0]);

endmodule

// File: tb/test_mc_bank.sv
`timescale 1ns/1ps
module test_mc_bank;

    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_clk = 0, pt_clk = 0, clk_src_pt = 0, clk_invert = 0;
    logic preset_term = 0, clear_term = 0;
    logic [4*N-1:0] cell_cfg = '0;
    logic [N-1:0] sum_term = '0, oe_term = '0, pad_i = '0;
    logic [N-1:0] pad_o, pad_oe, fb_o;

    always #4 clk = ~clk;

    mc_bank #(.N_CELLS(N)) i_mc_bank (
        .clk(clk), .rst_n(rst_n), .pin_clk(pin_clk), .pt_clk(pt_clk),
        .clk_src_pt(clk_src_pt), .clk_invert(clk_invert),
        .preset_term(preset_term), .clear_term(clear_term),
        .cell_cfg(cell_cfg), .sum_term(sum_term), .oe_term(oe_term),
        .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe), .fb_o(fb_o)
    );

    typedef struct {
        logic [N-1:0] po;
        logic [N-1:0] oe;
        logic [N-1:0] fb;
        string        tag;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic         m_prev = 1'b1;
    logic [N-1:0] m_q = '0;

    task automatic check1(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // One cycle of stimulus: drive at the falling edge, predict after the next rising edge
    task automatic step(input string tag, input logic [N-1:0] s, input logic [N-1:0] oe,
                        input logic [N-1:0] pi, input logic pc, input logic ptc,
                        input logic src, input logic inv, input logic pre, input logic clr,
                        input bit mid_clear_check);
        exp_t e;
        logic sel, ld, v, pol;
        logic [2:0] md;
        @(negedge clk);
        sum_term = s; oe_term = oe; pad_i = pi; pin_clk = pc; pt_clk = ptc;
        clk_src_pt = src; clk_invert = inv; preset_term = pre; clear_term = clr;
        sel = (src ? ptc : pc) ^ inv;
        ld  = sel & ~m_prev;
        m_prev = sel;
        for (int i = 0; i < N; i++) begin
            if (clr) m_q[i] = 1'b0;
            else if (ld) m_q[i] = pre ? 1'b1 : s[i];
        end
        for (int i = 0; i < N; i++) begin
            md  = cell_cfg[4*i+1 +: 3];
            pol = cell_cfg[4*i];
            if (md > 3'd5) begin md = 3'd0; pol = 1'b1; end
            v = md[0] ? m_q[i] : s[i];
            e.po[i] = pol ? v : ~v;
            e.oe[i] = oe[i];
            case (md[2:1])
                2'd1:    e.fb[i] = s[i];
                2'd2:    e.fb[i] = m_q[i];
                default: e.fb[i] = pi[i];
            endcase
        end
        e.tag = tag;
        sb.push_back(e);
        if (mid_clear_check) begin
            #1;
            // R3: clear shows before any clock edge; cell5 stored-bit feedback, cell0 registered output
            check1("R3 mid-cycle clear fb", {7'b0, fb_o[5]}, 8'h00);
            check1("R3 mid-cycle clear pad", {7'b0, pad_o[0]}, 8'h00);
        end
    endtask

    // scoreboard monitor
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check1({e.tag, " pad_o"}, pad_o, e.po);
                check1({e.tag, " pad_oe"}, pad_oe, e.oe);
                check1({e.tag, " fb_o"}, fb_o, e.fb);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // cells: 0 reg hi pad-fb, 1 reg lo, 2 comb hi, 3 comb lo,
        // 4 comb hi sum-fb, 5 reg hi stored-fb, 6/7 unused codes
        cell_cfg = {4'b1111, 4'b1100, 4'b1011, 4'b0101,
                    4'b0000, 4'b0001, 4'b0010, 4'b0011};
        sum_term = 8'hFF; oe_term = 8'hFF;
        repeat (3) @(posedge clk);
        #2;
        // R11: stored bits are 0 during reset: cell0 reg hi drives 0, cell1 reg lo drives 1
        check1("R11 reset pad", {6'b0, pad_o[1:0]}, 8'h02);
        check1("R11 reset fb", {7'b0, fb_o[5]}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        //    tag                 sum    oe     pad_i  pin pt src inv pre clr mid
        step("R11 idle",          8'h00, 8'hFF, 8'h00, 0, 0, 0, 0, 0, 0, 0);
        step("R5 R6 R10 comb",    8'hA5, 8'hFF, 8'h3C, 0, 0, 0, 0, 0, 0, 0);
        step("R1 capture",        8'hA5, 8'hFF, 8'h3C, 1, 0, 0, 0, 0, 0, 0);
        step("R1 hold",           8'h5A, 8'hFF, 8'hC3, 1, 0, 0, 0, 0, 0, 0);
        step("R1 low",            8'h5A, 8'hFF, 8'hC3, 0, 0, 0, 0, 0, 0, 0);
        step("R1 capture2",       8'h5A, 8'hFF, 8'hC3, 1, 0, 0, 0, 0, 0, 0);
        step("R9 pin low",        8'hF0, 8'hFF, 8'h00, 0, 0, 0, 0, 0, 0, 0);
        step("R9 unselected pt",  8'hF0, 8'hFF, 8'h00, 0, 1, 0, 0, 0, 0, 0);
        step("R9 switch to pt",   8'h0F, 8'hFF, 8'h00, 0, 1, 1, 0, 0, 0, 0);
        step("R9 pt low",         8'hCC, 8'hFF, 8'h00, 0, 0, 1, 0, 0, 0, 0);
        step("R9 pt rise",        8'hCC, 8'hFF, 8'h00, 0, 1, 1, 0, 0, 0, 0);
        step("R9 inv pin high",   8'h33, 8'hFF, 8'h00, 1, 0, 0, 1, 0, 0, 0);
        step("R9 inv pin fall",   8'h33, 8'hFF, 8'h00, 0, 0, 0, 1, 0, 0, 0);
        step("R2 preset no edge", 8'h00, 8'hFF, 8'h00, 0, 0, 0, 1, 1, 0, 0);
        step("R2 rearm",          8'h00, 8'hFF, 8'h00, 1, 0, 0, 1, 0, 0, 0);
        step("R2 preset edge",    8'h00, 8'hFF, 8'h00, 0, 0, 0, 1, 1, 0, 0);
        step("R3 clear",          8'h00, 8'hFF, 8'h00, 0, 0, 0, 1, 0, 1, 1);
        step("R3 after clear",    8'h00, 8'hFF, 8'h00, 0, 0, 0, 1, 0, 0, 0);
        step("R4 rearm",          8'hFF, 8'hFF, 8'h00, 1, 0, 0, 1, 0, 0, 0);
        step("R4 fill",           8'hFF, 8'hFF, 8'h00, 0, 0, 0, 1, 0, 0, 0);
        step("R4 rearm2",         8'hFF, 8'hFF, 8'h00, 1, 0, 0, 1, 0, 0, 0);
        step("R4 clear vs preset",8'hFF, 8'hFF, 8'h00, 0, 0, 0, 1, 1, 1, 0);
        step("R7 partial enable", 8'h96, 8'h0F, 8'h69, 0, 0, 0, 1, 0, 0, 0);
        step("R8 released sum fb",8'h10, 8'h00, 8'hEF, 0, 0, 0, 1, 0, 0, 0);
        step("R8 released sum fb2",8'hEF,8'h00, 8'h10, 0, 0, 0, 1, 0, 0, 0);
        step("R10 unused codes",  8'hC0, 8'h00, 8'h80, 0, 0, 0, 1, 0, 0, 0);
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule